// File: doc/BRIEF.md
# Canonical Signed Digit Recoder

This block takes an unsigned weight of `W` bits and rewrites it as a signed-digit number of `W+1` digits, each digit being -1, 0 or +1. Wherever the weight holds a long stretch of adjacent ones, the stretch collapses into a single -1 at its bottom and a single +1 one place above its top. The result has fewer nonzero digits, so a bit-serial constant multiplier built from it needs fewer adders. The recoded weight leaves the block as two plain unsigned words. One word marks the +1 digits and the other marks the -1 digits. The weight equals the first word minus the second.

The scan is sequential and handles one digit position per clock, starting at bit 0. A one-cycle `start` pulse while the block is idle captures the weight. `busy` stays high during the scan. `done` pulses for one cycle when both words are final. A stretch of exactly two ones gains nothing from recoding, so an internal pseudo-random sequence chooses its form each time one is found. This spreads the digits evenly between the two words.

Top module: `csd_recoder`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both `pos_digits` and `neg_digits` are all zeros.
- R2: When `start` is sampled high while idle, `busy` is high from the next cycle. `done` is high only in the single cycle that follows the (W+1)-th clock edge after the start edge. `busy` is low in that same cycle.
- R3: When `done` is high, `pos_digits - neg_digits` equals the captured weight.
- R4: When `done` is high, no bit position is set in both `pos_digits` and `neg_digits`.
- R5: The total count of set bits in `pos_digits` and `neg_digits` never exceeds the count of set bits in the weight.
- R6: A one that has zeros (or the word edges) on both sides stays a +1 at its own position in `pos_digits`.
- R7: A stretch of three or more adjacent ones, from bit `lo` to bit `hi`, becomes `neg_digits[lo]=1` and `pos_digits[hi+1]=1`, with no digits set in between. Position W counts as a zero.
- R8: A stretch of exactly two ones at bits `lo` and `lo+1` becomes one of two forms. The first is `neg_digits[lo]` and `pos_digits[lo+2]`. The second is `pos_digits[lo]` and `pos_digits[lo+1]`. Both forms occur over a sweep of all weights. The internal random state never reaches zero.
- R9: A `start` pulse while `busy` is high is ignored. The running conversion finishes with the same timing and the same result.
- R10: While idle and without `start`, `pos_digits` and `neg_digits` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that captures `weight_in` and begins a conversion when idle |
| weight_in | input | W | Unsigned weight to recode |
| busy | output | 1 | High while positions are being scanned |
| done | output | 1 | One-cycle pulse when the outputs are final |
| pos_digits | output | W+1 | Positions holding a +1 digit |
| neg_digits | output | W+1 | Positions holding a -1 digit |

## Verification
The run tracker holds only an active flag and a start index. If it holds a wrong start index, or misses the end of a stretch, the two words stop summing to the weight. This shows up in the same `done` cycle as a difference error, an overlap, or an excess digit count. A miscounted position counter moves the `done` pulse earlier or later. It also shifts digits off the top, so the value check catches it even without the latency check. A stuck or reset-to-zero random source yields pairs in only one form, and the full sweep of all 256 weights at W=8 exposes this.

// File: rtl/csd_pkg.sv
package csd_pkg;

    // Controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    // Class of a finished stretch of ones, by its length
    typedef enum logic [1:0] {
        RUN_NONE   = 2'd0,
        RUN_SINGLE = 2'd1,
        RUN_PAIR   = 2'd2,
        RUN_LONG   = 2'd3
    } run_kind_e;

    // Event emitted when a stretch of ones closes
    typedef struct packed {
        logic      valid;
        run_kind_e kind;
    } run_event_t;

    function automatic run_kind_e classify_run(input int unsigned len);
        if (len == 0)      return RUN_NONE;
        else if (len == 1) return RUN_SINGLE;
        else if (len == 2) return RUN_PAIR;
        else               return RUN_LONG;
    endfunction

    // Index width able to address positions 0..n
    function automatic int unsigned pos_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/csd_lfsr.sv
module csd_lfsr #(
    parameter int unsigned       LFSR_W = 16,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hB400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic              coin,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] st_q;
    logic [LFSR_W-1:0] st_next;

    // Galois form: shift right, fold the taps in when a one drops out
    always_comb begin
        st_next = st_q >> 1;
        if (st_q[0]) st_next = st_next ^ TAPS;
    end

    always_ff @(posedge clk) begin
        if (rst)          st_q <= SEED;
        else if (advance) st_q <= st_next;
    end

    assign coin  = st_q[0];
    assign state = st_q;
endmodule

// File: rtl/csd_run_scanner.sv
module csd_run_scanner
    import csd_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = pos_bits(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             cur_bit,
    input  logic [IDX_W-1:0] cur_idx,
    output run_event_t       evt,
    output logic [IDX_W-1:0] run_lo,
    output logic [IDX_W-1:0] run_hi
);
    logic             active_q;
    logic [IDX_W-1:0] lo_q;
    logic [IDX_W-1:0] run_len;

    assign run_len = cur_idx - lo_q;

    // A stretch closes at the first zero seen while one is open
    always_comb begin
        evt.valid = step && active_q && !cur_bit;
        evt.kind  = evt.valid ? classify_run(32'(run_len)) : RUN_NONE;
    end

    assign run_lo = lo_q;
    assign run_hi = cur_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            lo_q     <= '0;
        end else if (load) begin
            active_q <= 1'b0;
            lo_q     <= '0;
        end else if (step) begin
            if (cur_bit && !active_q) begin
                active_q <= 1'b1;
                lo_q     <= cur_idx;
            end else if (!cur_bit) begin
                active_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/csd_digit_accum.sv
module csd_digit_accum
    import csd_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = pos_bits(W),
    localparam int unsigned DW   = W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  run_event_t       evt,
    input  logic [IDX_W-1:0] run_lo,
    input  logic [IDX_W-1:0] run_hi,
    input  logic             coin,
    output logic [DW-1:0]    pos_q,
    output logic [DW-1:0]    neg_q
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] lo_mask;
    logic [DW-1:0] lo_up_mask;
    logic [DW-1:0] hi_mask;
    logic [DW-1:0] pos_set;
    logic [DW-1:0] neg_set;

    assign lo_mask    = ONE << run_lo;
    assign lo_up_mask = ONE << (run_lo + IDX_W'(1));
    assign hi_mask    = ONE << run_hi;

    always_comb begin
        pos_set = '0;
        neg_set = '0;
        if (evt.valid) begin
            unique case (evt.kind)
                RUN_SINGLE: pos_set = lo_mask;
                RUN_PAIR: begin
                    if (coin) begin
                        neg_set = lo_mask;
                        pos_set = hi_mask;
                    end else begin
                        pos_set = lo_mask | lo_up_mask;
                    end
                end
                RUN_LONG: begin
                    neg_set = lo_mask;
                    pos_set = hi_mask;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos_q <= '0;
            neg_q <= '0;
        end else begin
            pos_q <= pos_q | pos_set;
            neg_q <= neg_q | neg_set;
        end
    end
endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
    import csd_pkg::*;
#(
    parameter int unsigned       W      = 8,
    parameter int unsigned       LFSR_W = 16,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hB400
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] weight_in,
    output logic         busy,
    output logic         done,
    output logic [W:0]   pos_digits,
    output logic [W:0]   neg_digits
);
    localparam int unsigned IDX_W = pos_bits(W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(W);

    scan_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic [W-1:0]     shreg_q;
    logic             done_q;
    logic             launch;
    logic             step;
    logic             at_last;

    run_event_t       evt;
    logic [IDX_W-1:0] run_lo;
    logic [IDX_W-1:0] run_hi;
    logic             coin;
    logic [LFSR_W-1:0] lfsr_state;

    assign launch  = start && (state_q == ST_IDLE);
    assign step    = (state_q == ST_SCAN);
    assign at_last = (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            shreg_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                state_q <= ST_SCAN;
                idx_q   <= '0;
                shreg_q <= weight_in;
            end else if (step) begin
                shreg_q <= shreg_q >> 1;
                if (at_last) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    csd_run_scanner #(.W(W), .IDX_W(IDX_W)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .load    (launch),
        .step    (step),
        .cur_bit (shreg_q[0]),
        .cur_idx (idx_q),
        .evt     (evt),
        .run_lo  (run_lo),
        .run_hi  (run_hi)
    );

    csd_lfsr #(.LFSR_W(LFSR_W), .SEED(SEED), .TAPS(TAPS)) u_rng (
        .clk     (clk),
        .rst     (rst),
        .advance (evt.valid && (evt.kind == RUN_PAIR)),
        .coin    (coin),
        .state   (lfsr_state)
    );

    csd_digit_accum #(.W(W), .IDX_W(IDX_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (launch),
        .evt    (evt),
        .run_lo (run_lo),
        .run_hi (run_hi),
        .coin   (coin),
        .pos_q  (pos_digits),
        .neg_q  (neg_digits)
    );

    assign busy = step;
    assign done = done_q;
endmodule

// File: rtl/csd_recoder_chk.sv
module csd_recoder_chk #(
    parameter int unsigned W      = 8,
    parameter int unsigned LFSR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [W-1:0]      weight_in,
    input logic              busy,
    input logic              done,
    input logic [W:0]        pos_digits,
    input logic [W:0]        neg_digits,
    input logic [LFSR_W-1:0] lfsr_state
);
    localparam int unsigned CW = $clog2(W + 2) + 1;

    logic [W-1:0]  w_copy;
    logic [CW-1:0] scan_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_copy   <= '0;
            scan_cnt <= '0;
        end else if (start && !busy) begin
            w_copy   <= weight_in;
            scan_cnt <= '0;
        end else if (busy) begin
            scan_cnt <= scan_cnt + CW'(1);
        end
    end

    AST_SCAN_LEN: assert property (@(posedge clk) disable iff (rst)
        done |-> (scan_cnt == CW'(W + 1)));                              // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                 // R2
    AST_VALUE_KEPT: assert property (@(posedge clk) disable iff (rst)
        done |-> (({1'b0, pos_digits} - {1'b0, neg_digits}) == {2'b00, w_copy})); // R3
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        done |-> ((pos_digits & neg_digits) == '0));                    // R4
    AST_DIGIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> (($countones(pos_digits) + $countones(neg_digits)) <= $countones(w_copy))); // R5
    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0);                                               // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(pos_digits) && $stable(neg_digits))); // R10
endmodule

bind csd_recoder csd_recoder_chk #(.W(W), .LFSR_W(LFSR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .weight_in  (weight_in),
    .busy       (busy),
    .done       (done),
    .pos_digits (pos_digits),
    .neg_digits (neg_digits),
    .lfsr_state (lfsr_state)
);

// File: tb/tb_csd_recoder.sv
module tb_csd_recoder;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] weight_in = '0;
    logic         busy;
    logic         done;
    logic [W:0]   pos_digits;
    logic [W:0]   neg_digits;

    int n_checks = 0;
    int n_errors = 0;
    int pair_rec = 0;
    int pair_keep = 0;
    int cycles = 0;

    csd_recoder #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .weight_in(weight_in),
        .busy(busy), .done(done), .pos_digits(pos_digits), .neg_digits(neg_digits)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected words from the stretch rules; pair form read from the observed neg bit
    task automatic expect_words(input logic [W-1:0] v, input logic [W:0] obs_n,
                                output logic [W:0] ep, output logic [W:0] en,
                                output int pairs, output int longs);
        int lo;
        bit open;
        ep = '0; en = '0; pairs = 0; longs = 0; open = 0; lo = 0;
        for (int i = 0; i <= W; i++) begin
            bit b;
            b = (i < W) ? v[i] : 1'b0;
            if (b && !open) begin
                open = 1; lo = i;
            end else if (!b && open) begin
                open = 0;
                if (i - lo == 1) begin
                    ep[lo] = 1'b1;
                end else if (i - lo == 2) begin
                    pairs++;
                    if (obs_n[lo]) begin
                        en[lo] = 1'b1; ep[i] = 1'b1; pair_rec++;
                    end else begin
                        ep[lo] = 1'b1; ep[lo+1] = 1'b1; pair_keep++;
                    end
                end else begin
                    longs++;
                    en[lo] = 1'b1; ep[i] = 1'b1;
                end
            end
        end
    endtask

    task automatic convert(input logic [W-1:0] v);
        logic [W:0] p, n, ep, en;
        int pairs, longs;
        @(negedge clk);
        weight_in = v;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
        for (int k = 1; k < W + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(done == 1'b0, "R2", "done early", 32'(done), 0);
        end
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b1, "R2", "done at W+1", 32'(done), 1);
        check(busy == 1'b0, "R2", "busy at done", 32'(busy), 0);
        p = pos_digits;
        n = neg_digits;
        check(({1'b0, p} - {1'b0, n}) == {2'b00, v}, "R3", "value", 32'(p - n), 32'(v));
        check((p & n) == '0, "R4", "overlap", 32'(p & n), 0);
        check(($countones(p) + $countones(n)) <= $countones(v), "R5", "digit count",
              32'($countones(p) + $countones(n)), 32'($countones(v)));
        expect_words(v, n, ep, en, pairs, longs);
        if (pairs > 0) begin
            check(p == ep, "R8", "pos word", 32'(p), 32'(ep));
            check(n == en, "R8", "neg word", 32'(n), 32'(en));
        end else if (longs > 0) begin
            check(p == ep, "R7", "pos word", 32'(p), 32'(ep));
            check(n == en, "R7", "neg word", 32'(n), 32'(en));
        end else begin
            check(p == ep, "R6", "pos word", 32'(p), 32'(ep));
            check(n == en, "R6", "neg word", 32'(n), 32'(en));
        end
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R2", "done pulse width", 32'(done), 0);
        weight_in = ~v;
        @(posedge clk);
        @(negedge clk);
        check(pos_digits == p && neg_digits == n, "R10", "idle hold",
              32'({pos_digits, neg_digits}), 32'({p, n}));
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0 && done == 1'b0, "R1", "flags after reset", 32'({busy, done}), 0);
        check(pos_digits == '0 && neg_digits == '0, "R1", "words after reset",
              32'({pos_digits, neg_digits}), 0);

        // Directed patterns: isolated ones, long stretch at top, full word
        convert(8'h55);
        check(pos_digits == 9'h055 && neg_digits == '0, "R6", "0x55 words",
              32'({pos_digits, neg_digits}), 32'({9'h055, 9'h000}));
        convert(8'hF0);
        check(pos_digits == 9'h100 && neg_digits == 9'h010, "R7", "0xF0 words",
              32'({pos_digits, neg_digits}), 32'({9'h100, 9'h010}));
        convert(8'hFF);
        check(pos_digits == 9'h100 && neg_digits == 9'h001, "R7", "0xFF words",
              32'({pos_digits, neg_digits}), 32'({9'h100, 9'h001}));

        // R9: start while busy is ignored
        @(negedge clk);
        weight_in = 8'h07;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        weight_in = 8'hAA;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 4; k < W + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(done == 1'b0, "R9", "done early after ignored start", 32'(done), 0);
        end
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b1, "R9", "done timing kept", 32'(done), 1);
        check(pos_digits == 9'h008 && neg_digits == 9'h001, "R9", "result kept",
              32'({pos_digits, neg_digits}), 32'({9'h008, 9'h001}));

        // Exhaustive sweep of all weights
        for (int v = 0; v < (1 << W); v++) convert(W'(v));
        check(pair_rec > 0, "R8", "recoded pair form seen", 32'(pair_rec), 1);
        check(pair_keep > 0, "R8", "kept pair form seen", 32'(pair_keep), 1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule